// File: doc/BRIEF.md
# SEC-DED Protected Parameter Register Bank

This block holds a set of 16-bit configuration parameters in a form that survives radiation upsets. Each parameter is kept as a 22-bit codeword: 16 data bits, 5 Hamming check bits and one overall parity bit. A byte-wide configuration bus writes each parameter in two halves. The word is encoded and stored only when its upper byte arrives. The decoded data of every entry is always presented in parallel to downstream processing logic.

The bank has no decoder per entry. A single shared SEC-DED decoder is steered by a scrub pointer that visits one entry per clock and wraps around. When the visited word holds a single-bit error, the corrected word is written back in the same slot. When it holds a double-bit error, the word is flagged and left untouched. Sticky flags record corrected events, uncorrectable events and their logical OR, until an explicit clear.

The byte assembler is a two-state machine. In `WF_IDLE`, a low-byte write moves it to `WF_LOW_HELD`, and a high-byte write commits using the stored low byte. In `WF_LOW_HELD`, a further low-byte write stays in `WF_LOW_HELD` and overwrites the staged byte. A high-byte write returns it to `WF_IDLE` and commits. The staged byte is used only if it belongs to the same entry; otherwise it is discarded. The shared decoder sorts each visited word into `CLS_CLEAN`, `CLS_FIX` or `CLS_BAD`. A fault-injection port lets test logic flip stored bits.

Top module: `sec_ded_param_bank`

## Requirements
- R1: Bit 0 of a stored codeword is even parity over all 22 bits. Check bits sit at positions 1, 2, 4, 8 and 16. Data bit k occupies the k-th remaining position counted upward from 3, so data bit 0 is at 3, data bit 1 at 5, data bit 2 at 6, and data bit 15 at 21. Words written through the bus are valid codewords and raise no error flag.
- R2: Byte address 2*i writes the low byte of entry i, and byte address 2*i+1 writes its high byte. A low-byte write alone leaves `param_data` unchanged. A high-byte write updates entry i by the clock edge that samples it.
- R3: A high-byte write combines with the staged low byte only if the last low-byte write targeted the same entry. Otherwise the entry keeps its stored low byte, and the staged byte is discarded.
- R4: A single flipped bit at any of the 22 positions, including the parity bit, is corrected in storage within one full scan of the bank. Such a correction sets `flag_fixed`.
- R5: When two bits are flipped in one entry, that entry is reported through `flag_fatal` on every visit. The entry is left unchanged in storage, with no miscorrection.
- R6: `scan_idx` is 0 in reset. Afterwards it advances by one every clock and wraps from NUM_REGS-1 to 0.
- R7: A valid bus write whose entry equals the current `scan_idx` holds `scan_idx` for that clock. Writes to other entries do not hold it.
- R8: `flag_fixed` and `flag_fatal` are sticky until `flag_clear`. `flag_any` always equals their OR. A set event in the same clock as a clear wins over the clear.
- R9: In reset every entry holds the all-zero codeword, so `param_data` is all zero and all flags are low.
- R10: While `seu_en` is high, `seu_mask` is XORed into the stored codeword of entry `seu_reg` at the clock edge.
- R11: Writes to byte addresses at or above 2*NUM_REGS change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | IDX_W+1 | Byte address; bit 0 selects the high byte |
| cfg_byte | input | 8 | Write data byte |
| flag_clear | input | 1 | Clears the sticky error flags |
| seu_en | input | 1 | Applies the fault-injection mask |
| seu_reg | input | IDX_W | Entry hit by the injection |
| seu_mask | input | 22 | Bits flipped in the stored codeword |
| param_data | output | NUM_REGS*16 | Decoded data of all entries, entry i in bits [16i+15:16i] |
| scan_idx | output | IDX_W | Entry visited by the shared decoder this cycle |
| flag_any | output | 1 | Sticky OR of all error events |
| flag_fixed | output | 1 | Sticky: a single-bit error was corrected |
| flag_fatal | output | 1 | Sticky: an uncorrectable error was seen |

## Verification
The bench builds the bank with its defaults: twelve entries and a 4-bit scan pointer. With this size the wrap from 11 back to 0 is reached twice within a couple of dozen cycles. A full scrub pass fits within 13 cycles of an injection, which makes it practical to sweep a single flipped bit through all 22 codeword positions. The byte address field also keeps eight unused addresses (24 to 31), so writes to addresses that map to no entry can be driven directly.

// File: rtl/psb_pkg.sv
package psb_pkg;

    localparam int DATA_W = 16;
    localparam int CHK_W  = 5;
    localparam int CW     = DATA_W + CHK_W + 1;
    localparam int BYTE_W = 8;

    typedef logic [CW-1:0]     code_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        CLS_CLEAN,
        CLS_FIX,
        CLS_BAD
    } cls_t;

    function automatic logic is_chk_pos(input int p);
        return ((p & (p - 1)) == 0);
    endfunction

    function automatic syn_t syndrome(input code_t w);
        syn_t s;
        s = '0;
        for (int p = 1; p < CW; p++) begin
            if (w[p]) s = s ^ syn_t'(p);
        end
        return s;
    endfunction

    function automatic code_t encode(input data_t d);
        code_t w;
        syn_t  s;
        int    k;
        w = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if (!is_chk_pos(p)) begin
                w[p] = d[k];
                k++;
            end
        end
        s = syndrome(w);
        for (int j = 0; j < CHK_W; j++) begin
            w[1 << j] = s[j];
        end
        w[0] = ^w[CW-1:1];
        return w;
    endfunction

    function automatic data_t extract(input code_t w);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if (!is_chk_pos(p)) begin
                d[k] = w[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/psb_codec.sv
module psb_codec
    import psb_pkg::*;
(
    input  code_t word_i,
    output cls_t  cls_o,
    output code_t fixed_o
);

    syn_t syn;
    logic par;

    always_comb begin
        syn     = syndrome(word_i);
        par     = ^word_i;
        fixed_o = word_i;
        cls_o   = CLS_CLEAN;
        if (par) begin
            if (int'(syn) < CW) begin
                fixed_o = word_i ^ (code_t'(1) << syn);
                cls_o   = CLS_FIX;
            end else begin
                cls_o   = CLS_BAD;
            end
        end else if (syn != '0) begin
            cls_o = CLS_BAD;
        end
    end

endmodule

// File: rtl/psb_wr_fsm.sv
module psb_wr_fsm
    import psb_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = 4,
    parameter int ADDR_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] lo_i [NUM_REGS],
    output logic              valid_o,
    output logic [IDX_W-1:0]  reg_o,
    output logic              commit_o,
    output data_t             commit_data_o
);

    localparam int SLOTS = 2 * NUM_REGS;

    typedef enum logic {
        WF_IDLE,
        WF_LOW_HELD
    } wf_t;

    wf_t               state_q, state_d;
    logic [BYTE_W-1:0] lo_q;
    logic [IDX_W-1:0]  lo_idx_q;
    logic              is_hi;
    logic [BYTE_W-1:0] stored_lo;
    logic [BYTE_W-1:0] lo_sel;

    assign valid_o = we_i && ({1'b0, addr_i} < (ADDR_W+1)'(SLOTS));
    assign reg_o   = addr_i[ADDR_W-1:1];
    assign is_hi   = addr_i[0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WF_IDLE: begin
                if (valid_o && !is_hi) state_d = WF_LOW_HELD;
            end
            WF_LOW_HELD: begin
                if (valid_o && is_hi) state_d = WF_IDLE;
            end
            default: state_d = WF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WF_IDLE;
            lo_q     <= '0;
            lo_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (valid_o && !is_hi) begin
                lo_q     <= byte_i;
                lo_idx_q <= reg_o;
            end
        end
    end

    always_comb begin
        stored_lo = '0;
        if (int'(reg_o) < NUM_REGS) stored_lo = lo_i[reg_o];
        lo_sel = ((state_q == WF_LOW_HELD) && (lo_idx_q == reg_o)) ? lo_q : stored_lo;
        commit_o      = valid_o && is_hi;
        commit_data_o = {byte_i, lo_sel};
    end

endmodule

// File: rtl/psb_scrub.sv
module psb_scrub
    import psb_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pause_i,
    input  cls_t             cls_i,
    input  logic             clear_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             wb_o,
    output logic             any_o,
    output logic             fixed_o,
    output logic             fatal_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0] idx_q;
    logic             ev_fix, ev_bad;
    logic             any_q, fixed_q, fatal_q;

    assign ev_fix = !pause_i && (cls_i == CLS_FIX);
    assign ev_bad = !pause_i && (cls_i == CLS_BAD);
    assign wb_o   = ev_fix;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            any_q   <= 1'b0;
            fixed_q <= 1'b0;
            fatal_q <= 1'b0;
        end else begin
            if (!pause_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            fixed_q <= ev_fix | (fixed_q & ~clear_i);
            fatal_q <= ev_bad | (fatal_q & ~clear_i);
            any_q   <= ev_fix | ev_bad | (any_q & ~clear_i);
        end
    end

    assign idx_o   = idx_q;
    assign any_o   = any_q;
    assign fixed_o = fixed_q;
    assign fatal_o = fatal_q;

    assert_scan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_i |=> idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1));

    assert_scan_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_q) < NUM_REGS);

    assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_i |=> $stable(idx_q));

    assert_fixed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_q && !clear_i |=> fixed_q);

    assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_q && !clear_i |=> fatal_q);

    assert_summary_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_q == (fixed_q || fatal_q));

endmodule

// File: rtl/sec_ded_param_bank.sv
module sec_ded_param_bank
    import psb_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter int ADDR_W   = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [BYTE_W-1:0]          cfg_byte,
    input  logic                       flag_clear,
    input  logic                       seu_en,
    input  logic [IDX_W-1:0]           seu_reg,
    input  logic [CW-1:0]              seu_mask,
    output logic [NUM_REGS*DATA_W-1:0] param_data,
    output logic [IDX_W-1:0]           scan_idx,
    output logic                       flag_any,
    output logic                       flag_fixed,
    output logic                       flag_fatal
);

    code_t             mem_q [NUM_REGS];
    code_t             mem_d [NUM_REGS];
    logic [BYTE_W-1:0] lo_bytes [NUM_REGS];

    logic             wr_valid;
    logic [IDX_W-1:0] wr_reg;
    logic             commit;
    data_t            commit_data;
    code_t            commit_word;
    logic             pause;
    logic             wb;
    cls_t             scrub_cls;
    code_t            scrub_word;
    code_t            scrub_fixed;

    psb_wr_fsm #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W)
    ) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (cfg_we),
        .addr_i        (cfg_addr),
        .byte_i        (cfg_byte),
        .lo_i          (lo_bytes),
        .valid_o       (wr_valid),
        .reg_o         (wr_reg),
        .commit_o      (commit),
        .commit_data_o (commit_data)
    );

    assign commit_word = encode(commit_data);
    assign pause       = wr_valid && (wr_reg == scan_idx);
    assign scrub_word  = mem_q[scan_idx];

    psb_codec u_codec (
        .word_i  (scrub_word),
        .cls_o   (scrub_cls),
        .fixed_o (scrub_fixed)
    );

    psb_scrub #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_scrub (
        .clk     (clk),
        .rst_n   (rst_n),
        .pause_i (pause),
        .cls_i   (scrub_cls),
        .clear_i (flag_clear),
        .idx_o   (scan_idx),
        .wb_o    (wb),
        .any_o   (flag_any),
        .fixed_o (flag_fixed),
        .fatal_o (flag_fatal)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (commit && (wr_reg == IDX_W'(g))) begin
                mem_d[g] = commit_word;
            end else if (wb && (scan_idx == IDX_W'(g))) begin
                mem_d[g] = scrub_fixed;
            end
            if (seu_en && (seu_reg == IDX_W'(g))) begin
                mem_d[g] = mem_d[g] ^ seu_mask;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end

        assign param_data[g*DATA_W +: DATA_W] = extract(mem_q[g]);
        assign lo_bytes[g] = param_data[g*DATA_W +: BYTE_W];
    end

    assert_fix_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_cls == CLS_FIX |-> (syndrome(scrub_fixed) == '0) && !(^scrub_fixed));

    assert_bad_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_cls == CLS_BAD) && !pause && !(seu_en && (seu_reg == scan_idx))
        |=> mem_q[$past(scan_idx)] == $past(scrub_word));

endmodule

// File: tb/sec_ded_param_bank_tb.sv
`timescale 1ns/1ps
module sec_ded_param_bank_tb;

    localparam int NR = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [4:0]     cfg_addr = '0;
    logic [7:0]     cfg_byte = '0;
    logic           flag_clear = 1'b0;
    logic           seu_en = 1'b0;
    logic [3:0]     seu_reg = '0;
    logic [21:0]    seu_mask = '0;
    logic [NR*16-1:0] param_data;
    logic [3:0]     scan_idx;
    logic           flag_any, flag_fixed, flag_fatal;

    always #2.5 clk = ~clk;

    sec_ded_param_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_byte(cfg_byte), .flag_clear(flag_clear), .seu_en(seu_en),
        .seu_reg(seu_reg), .seu_mask(seu_mask), .param_data(param_data),
        .scan_idx(scan_idx), .flag_any(flag_any), .flag_fixed(flag_fixed),
        .flag_fatal(flag_fatal)
    );

    typedef struct {
        string       req;
        int          sel;
        int          idx;
        logic [31:0] exp;
    } item_t;

    item_t       sb_q[$];
    event        chk_ev;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [15:0] model [NR];

    function automatic logic [31:0] observe(input int sel, input int idx);
        case (sel)
            0:       return 32'(param_data[idx*16 +: 16]);
            1:       return 32'(scan_idx);
            default: return 32'({flag_any, flag_fixed, flag_fatal});
        endcase
    endfunction

    always @(chk_ev) begin
        while (sb_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = observe(it.sel, it.idx);
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s sel=%0d idx=%0d actual=%h expected=%h",
                         it.req, it.sel, it.idx, act, it.exp);
            end
        end
    end

    task automatic expect_v(input string req, input int sel, input int idx, input logic [31:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.idx = idx; it.exp = e;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic expect_all(input string req);
        for (int r = 0; r < NR; r++) expect_v(req, 0, r, 32'(model[r]));
    endtask

    task automatic write_byte(input int addr, input logic [7:0] b);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_byte = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_word(input int r, input logic [15:0] v);
        write_byte(2*r, v[7:0]);
        write_byte(2*r+1, v[15:8]);
        model[r] = v;
    endtask

    task automatic inject(input int r, input logic [21:0] m);
        seu_en = 1'b1; seu_reg = 4'(r); seu_mask = m;
        @(negedge clk);
        seu_en = 1'b0;
    endtask

    task automatic pulse_clear();
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
    endtask

    function automatic int dpos(input int pos);
        int k;
        if ((pos & (pos - 1)) == 0) return -1;
        k = 0;
        for (int p = 1; p < pos; p++) if ((p & (p - 1)) != 0) k++;
        return k;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        for (int r = 0; r < NR; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        expect_all("R9 reset data");
        expect_v("R9 reset flags", 2, 0, 32'h0);
        expect_v("R9 reset scan", 1, 0, 32'h0);
        rst_n = 1'b1;

        // R6 stepping and wrap
        for (int k = 0; k < 26; k++) begin
            expect_v("R6 scan step", 1, 0, 32'(k % NR));
            @(negedge clk);
        end

        // R1 R2 full writes
        for (int r = 0; r < NR; r++)
            write_word(r, 16'((r + 1) * 16'h1357) ^ 16'hA0F0);
        expect_all("R2 word write");
        repeat (30) @(negedge clk);
        expect_v("R1 valid codewords no flag", 2, 0, 32'h0);

        // R2 low only, R3 staging rules
        write_byte(8, 8'hEE);
        expect_v("R2 low byte alone", 0, 4, 32'(model[4]));
        write_byte(13, 8'h22);
        model[6] = {8'h22, model[6][7:0]};
        expect_v("R3 high without staged low", 0, 6, 32'(model[6]));
        expect_v("R3 other entry untouched", 0, 4, 32'(model[4]));
        write_byte(9, 8'h33);
        model[4] = {8'h33, model[4][7:0]};
        expect_v("R3 staged byte discarded", 0, 4, 32'(model[4]));

        // R11 out-of-range addresses
        write_byte(24, 8'hFF);
        write_byte(31, 8'hFF);
        expect_all("R11 ignored address");

        // R7 pause on collision
        s = int'(scan_idx);
        cfg_we = 1'b1; cfg_addr = 5'(2*s); cfg_byte = 8'h5A;
        @(negedge clk);
        cfg_we = 1'b0;
        expect_v("R7 hold on collision", 1, 0, 32'(s));
        @(negedge clk);
        expect_v("R7 resume after hold", 1, 0, 32'((s + 1) % NR));
        s = int'(scan_idx);
        cfg_we = 1'b1; cfg_addr = 5'(2*((s + 5) % NR)); cfg_byte = 8'h5A;
        @(negedge clk);
        cfg_we = 1'b0;
        expect_v("R7 no hold other entry", 1, 0, 32'((s + 1) % NR));
        s = int'(scan_idx);
        cfg_we = 1'b1; cfg_addr = 5'(2*s + 1); cfg_byte = 8'h77;
        @(negedge clk);
        cfg_we = 1'b0;
        model[s] = {8'h77, model[s][7:0]};
        expect_v("R7 hold on high-byte commit", 1, 0, 32'(s));
        expect_v("R3 commit during hold", 0, s, 32'(model[s]));

        // R4 R10 single-bit sweep
        for (int pos = 0; pos < 22; pos++) begin
            int k;
            logic [15:0] corrupt;
            k = dpos(pos);
            corrupt = model[7];
            if (k >= 0) corrupt = corrupt ^ (16'h1 << k);
            inject(7, 22'h1 << pos);
            expect_v("R10 injected bit visible", 0, 7, 32'(corrupt));
            repeat (13) @(negedge clk);
            expect_v("R4 corrected", 0, 7, 32'(model[7]));
            expect_v("R4 fixed flag", 2, 0, 32'h6);
            pulse_clear();
            expect_v("R8 cleared", 2, 0, 32'h0);
        end

        // R8 stickiness over many scans
        inject(0, 22'h1 << 10);
        repeat (40) @(negedge clk);
        expect_v("R8 sticky fixed", 2, 0, 32'h6);
        pulse_clear();
        expect_v("R8 clear", 2, 0, 32'h0);

        // R5 double errors
        write_word(2, 16'hA5C3);
        inject(2, (22'h1 << 3) | (22'h1 << 5));
        repeat (13) @(negedge clk);
        expect_v("R5 data left raw", 0, 2, 32'(model[2] ^ 16'h0003));
        expect_v("R5 fatal flag", 2, 0, 32'h5);
        repeat (12) @(negedge clk);
        expect_v("R5 still unchanged", 0, 2, 32'(model[2] ^ 16'h0003));
        pulse_clear();
        repeat (13) @(negedge clk);
        expect_v("R5 reflagged each visit", 2, 0, 32'h5);
        write_word(2, 16'h0F0F);
        pulse_clear();
        repeat (13) @(negedge clk);
        expect_v("R5 rewrite heals", 0, 2, 32'(model[2]));
        expect_v("R8 flags stay clear", 2, 0, 32'h0);
        inject(9, 22'h6);
        repeat (13) @(negedge clk);
        expect_v("R5 check-bit pair", 0, 9, 32'(model[9]));
        expect_v("R5 check-bit pair flag", 2, 0, 32'h5);
        pulse_clear();
        expect_all("R1 final contents");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule